// File: doc/BRIEF.md
# CAN Controller Disable Sequencer

This block takes a CAN controller core safely into a low-power disabled mode and brings it back out. When software raises the disable request, the sequencer does not gate anything at once. It first waits for a point where stopping cannot corrupt bus traffic. That point is an idle bus, a bus-off condition, or the third intermission bit sampled at the recessive level. It then waits for any buffer move-in or move-out operation still in progress to finish. Only after both conditions hold does it stop the protocol-engine and buffer-manager clocks, isolate the receive input and hold the transmit output recessive.

The mode is reported through two status bits. `not_ready_o` rises together with `dis_ack_o` on entry. When the request is cleared, the clocks restart and the acknowledge falls at once. The not-ready bit follows one cycle later, so software always sees the acknowledge drop first. While the block is disabled, the register front end uses `acc_blocked_o` to reject accesses to the timer, the error counters and the message buffers. All other registers remain reachable.

Top module: `can_disable_seq`

## Requirements
- R1: After `dis_req_i` is sampled high, the clocks stay enabled and `dis_ack_o` stays 0 until a safe bus point has been sampled. A safe point is `bus_idle_i`=1, or `bus_off_i`=1, or `bit_strobe_i`=1 with `imbit_idx_i`=3 and `bus_level_i`=1 (1 means recessive).
- R2: After the safe point, the block keeps the clocks enabled for as long as `move_busy_i` is sampled high. It enters disabled mode on the first edge at which `move_busy_i` is sampled low.
- R3: In disabled mode, `rx_ignore_o`=1 and `tx_recessive_o`=1. Outside it, both are 0.
- R4: In disabled mode, `pe_clk_en_o`=0 and `bm_clk_en_o`=0. In every other state, both are 1.
- R5: `dis_ack_o` and `not_ready_o` are both 1 throughout disabled mode. They are both 0 in normal operation.
- R6: `acc_blocked_o` is 1 only in disabled mode and only when `acc_sel_i` is 1 (timer), 2 (error counters) or 3 (message buffers). Code 0 (other registers) is never blocked.
- R7: When `dis_req_i` is sampled low in disabled mode, the next cycle shows both clocks enabled, `dis_ack_o`=0, and the isolation released.
- R8: On wake-up, `not_ready_o` stays 1 for exactly one cycle after `dis_ack_o` falls, and then returns to 0.
- R9: If `dis_req_i` is sampled low while waiting for the bus or for moves to drain, the block returns to normal operation on that edge. No clock is gated and no status bit is set.
- R10: After reset, the block is in normal operation: clocks enabled, isolation off, and every status and blocked output at 0.
- R11: A strobe at an intermission index other than 3, or at index 3 with a dominant level (`bus_level_i`=0), is not a safe point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_req_i | input | 1 | Disable request from the control register |
| bus_idle_i | input | 1 | Bus is idle |
| bus_off_i | input | 1 | Controller is bus-off |
| imbit_idx_i | input | IDX_W | 1-based intermission bit index |
| bit_strobe_i | input | 1 | Single-cycle strobe marking a valid bus-level sample |
| bus_level_i | input | 1 | Sampled bus level, 1 = recessive |
| move_busy_i | input | 1 | Buffer move-in or move-out is in progress |
| acc_sel_i | input | SEL_W | Register region being accessed |
| pe_clk_en_o | output | 1 | Protocol-engine clock enable |
| bm_clk_en_o | output | 1 | Buffer-manager clock enable |
| rx_ignore_o | output | 1 | Gate the receive input off |
| tx_recessive_o | output | 1 | Force the transmit output recessive |
| not_ready_o | output | 1 | Not-ready status bit |
| dis_ack_o | output | 1 | Disable-acknowledge status bit |
| acc_blocked_o | output | 1 | Access to the selected region is refused |

## Verification
The hardest situation to reach is a shutdown that depends on the third intermission bit. It needs a request already waiting and a strobe at index 3 at the recessive level, while idle and bus-off both stay low. A move must also still be busy when that strobe arrives, so the drain wait is actually exercised. Purely random inputs almost never line these events up. Directed sequences therefore hold idle and bus-off low, present first a dominant sample and then a wrong index, and only then the good strobe with the move flag raised. A long random phase afterwards shapes the input rates (sticky requests, rare idle, frequent strobes) so that aborts from both wait states and repeated wake-ups also occur.

// File: rtl/cds_pkg.sv
package cds_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WBUS  = 3'd1,
        ST_DRAIN = 3'd2,
        ST_OFF   = 3'd3,
        ST_WAKE  = 3'd4
    } cds_state_e;

    typedef struct packed {
        cds_state_e st;
        logic       safe_seen;
    } cds_regs_t;

endpackage

// File: rtl/cds_safe_point.sv
module cds_safe_point #(
    parameter int IDX_W       = 3,
    parameter int SAFE_BIT    = 3,
    parameter bit REC_IS_HIGH = 1'b1
) (
    input  logic             bus_idle_i,
    input  logic             bus_off_i,
    input  logic [IDX_W-1:0] imbit_idx_i,
    input  logic             bit_strobe_i,
    input  logic             bus_level_i,
    output logic             safe_o
);
    localparam logic [IDX_W-1:0] SAFE_IDX = IDX_W'(SAFE_BIT);

    logic recessive;

    generate
        if (REC_IS_HIGH) begin : g_rec_high
            assign recessive = bus_level_i;
        end else begin : g_rec_low
            assign recessive = ~bus_level_i;
        end
    endgenerate

    logic im_ok;
    assign im_ok  = bit_strobe_i && (imbit_idx_i == SAFE_IDX) && recessive;
    assign safe_o = bus_idle_i || bus_off_i || im_ok;

endmodule

// File: rtl/cds_fsm.sv
module cds_fsm
    import cds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dis_req_i,
    input  logic       safe_i,
    input  logic       move_busy_i,
    output cds_state_e state_o
);
    cds_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                r_d.safe_seen = 1'b0;
                if (dis_req_i) r_d.st = ST_WBUS;
            end
            ST_WBUS: begin
                if (!dis_req_i) begin
                    r_d.st = ST_RUN;
                end else if (safe_i) begin
                    r_d.st        = ST_DRAIN;
                    r_d.safe_seen = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (!dis_req_i) begin
                    r_d.st        = ST_RUN;
                    r_d.safe_seen = 1'b0;
                end else if (!move_busy_i) begin
                    r_d.st = ST_OFF;
                end
            end
            ST_OFF: begin
                if (!dis_req_i) begin
                    r_d.st        = ST_WAKE;
                    r_d.safe_seen = 1'b0;
                end
            end
            ST_WAKE: begin
                r_d.st = ST_RUN;
            end
            default: begin
                r_d.st        = ST_RUN;
                r_d.safe_seen = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_RUN;
            r_q.safe_seen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    // R1: disabled mode is reached only through a recorded safe bus point
    a_r1_safe_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WBUS) |=> (r_q.st != ST_OFF));

    // R1: leaving the bus wait toward the drain happens only on a safe sample
    a_r1_drain_needs_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WBUS && !safe_i) |=> (r_q.st != ST_DRAIN));

    // R2: a busy move holds off the gating
    a_r2_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DRAIN && move_busy_i) |=> (r_q.st != ST_OFF));

    // R1: the off state always has a recorded safe point behind it
    a_r1_off_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OFF) |-> r_q.safe_seen);

endmodule

// File: rtl/cds_out_decode.sv
module cds_out_decode
    import cds_pkg::*;
#(
    parameter int               SEL_W      = 2,
    parameter logic [(1<<SEL_W)-1:0] BLOCK_MASK = 4'b1110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cds_state_e       state_i,
    input  logic [SEL_W-1:0] acc_sel_i,
    output logic             pe_clk_en_o,
    output logic             bm_clk_en_o,
    output logic             rx_ignore_o,
    output logic             tx_recessive_o,
    output logic             not_ready_o,
    output logic             dis_ack_o,
    output logic             acc_blocked_o
);
    logic off;
    assign off = (state_i == ST_OFF);

    assign pe_clk_en_o    = !off;
    assign bm_clk_en_o    = !off;
    assign rx_ignore_o    = off;
    assign tx_recessive_o = off;
    assign dis_ack_o      = off;
    assign not_ready_o    = off || (state_i == ST_WAKE);
    assign acc_blocked_o  = off && BLOCK_MASK[acc_sel_i];

    // R5: acknowledge never appears without not-ready
    a_r5_ack_implies_nr: assert property (@(posedge clk) disable iff (!rst_n)
        dis_ack_o |-> not_ready_o);

    // R3: isolation accompanies the acknowledge
    a_r3_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        dis_ack_o |-> (rx_ignore_o && tx_recessive_o));

    // R4: clocks are stopped whenever acknowledged
    a_r4_clk_off: assert property (@(posedge clk) disable iff (!rst_n)
        dis_ack_o |-> (!pe_clk_en_o && !bm_clk_en_o));

    // R8: not-ready outlives the acknowledge by one cycle
    a_r8_nr_late: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_ack_o) |-> (not_ready_o && pe_clk_en_o));

    // R8: the cycle after that not-ready is clear
    a_r8_nr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dis_ack_o) |=> !not_ready_o);

    // R6: blocked access only while acknowledged
    a_r6_block_off_only: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blocked_o |-> dis_ack_o);

endmodule

// File: rtl/can_disable_seq.sv
module can_disable_seq
    import cds_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int SAFE_BIT = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis_req_i,
    input  logic             bus_idle_i,
    input  logic             bus_off_i,
    input  logic [IDX_W-1:0] imbit_idx_i,
    input  logic             bit_strobe_i,
    input  logic             bus_level_i,
    input  logic             move_busy_i,
    input  logic [SEL_W-1:0] acc_sel_i,
    output logic             pe_clk_en_o,
    output logic             bm_clk_en_o,
    output logic             rx_ignore_o,
    output logic             tx_recessive_o,
    output logic             not_ready_o,
    output logic             dis_ack_o,
    output logic             acc_blocked_o
);
    localparam int NREG = 1 << SEL_W;
    localparam logic [NREG-1:0] BLOCK_MASK = {{(NREG-1){1'b1}}, 1'b0};

    logic       safe;
    cds_state_e state;

    cds_safe_point #(
        .IDX_W      (IDX_W),
        .SAFE_BIT   (SAFE_BIT),
        .REC_IS_HIGH(1'b1)
    ) u_safe (
        .bus_idle_i  (bus_idle_i),
        .bus_off_i   (bus_off_i),
        .imbit_idx_i (imbit_idx_i),
        .bit_strobe_i(bit_strobe_i),
        .bus_level_i (bus_level_i),
        .safe_o      (safe)
    );

    cds_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_req_i  (dis_req_i),
        .safe_i     (safe),
        .move_busy_i(move_busy_i),
        .state_o    (state)
    );

    cds_out_decode #(
        .SEL_W     (SEL_W),
        .BLOCK_MASK(BLOCK_MASK)
    ) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .acc_sel_i     (acc_sel_i),
        .pe_clk_en_o   (pe_clk_en_o),
        .bm_clk_en_o   (bm_clk_en_o),
        .rx_ignore_o   (rx_ignore_o),
        .tx_recessive_o(tx_recessive_o),
        .not_ready_o   (not_ready_o),
        .dis_ack_o     (dis_ack_o),
        .acc_blocked_o (acc_blocked_o)
    );

    // R9: a withdrawn request during either wait leaves clocks and status untouched
    a_r9_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WBUS || state == ST_DRAIN) && !dis_req_i)
        |=> (pe_clk_en_o && bm_clk_en_o && !not_ready_o && !dis_ack_o));

    // R7: clearing the request in disabled mode restarts the clocks next cycle
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_ack_o && !dis_req_i) |=> (pe_clk_en_o && bm_clk_en_o && !dis_ack_o));

endmodule

// File: tb/can_disable_seq_tb.sv
module can_disable_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dis_req = 1'b0, bus_idle = 1'b0, bus_off = 1'b0;
    logic [2:0] imbit_idx = 3'd0;
    logic       bit_strobe = 1'b0, bus_level = 1'b0, move_busy = 1'b0;
    logic [1:0] acc_sel = 2'd0;
    logic pe_en, bm_en, rx_ign, tx_rec, nrdy, ack, blk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int unsigned seed_v = 32'd7;

    always #2 clk = ~clk;

    can_disable_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dis_req_i(dis_req), .bus_idle_i(bus_idle),
        .bus_off_i(bus_off), .imbit_idx_i(imbit_idx), .bit_strobe_i(bit_strobe),
        .bus_level_i(bus_level), .move_busy_i(move_busy), .acc_sel_i(acc_sel),
        .pe_clk_en_o(pe_en), .bm_clk_en_o(bm_en), .rx_ignore_o(rx_ign),
        .tx_recessive_o(tx_rec), .not_ready_o(nrdy), .dis_ack_o(ack),
        .acc_blocked_o(blk)
    );

    // Reference: 0 run, 1 wait bus, 2 wait drain, 3 off, 4 wake
    int m_st = 0;

    function automatic bit f_safe(bit idle, bit boff, bit stb, logic [2:0] idx, bit lvl);
        return idle || boff || (stb && idx == 3'd3 && lvl);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_st <= 0;
        else begin
            case (m_st)
                0: if (dis_req) m_st <= 1;
                1: if (!dis_req) m_st <= 0;
                   else if (f_safe(bus_idle, bus_off, bit_strobe, imbit_idx, bus_level)) m_st <= 2;
                2: if (!dis_req) m_st <= 0; else if (!move_busy) m_st <= 3;
                3: if (!dis_req) m_st <= 4;
                default: m_st <= 0;
            endcase
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all();
        bit off;
        off = (m_st == 3);
        chk("R4 pe_clk_en", pe_en, !off);
        chk("R4 bm_clk_en", bm_en, !off);
        chk("R3 rx_ignore", rx_ign, off);
        chk("R3 tx_recessive", tx_rec, off);
        chk("R5 dis_ack", ack, off);
        chk("R8 not_ready", nrdy, off || m_st == 4);
        chk("R6 acc_blocked", blk, off && acc_sel != 2'd0);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk_all();
    endtask

    task automatic quiet();
        bus_idle = 0; bus_off = 0; bit_strobe = 0; bus_level = 0;
        imbit_idx = 3'd0; move_busy = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 pe_clk_en", pe_en, 1'b1);
        chk("R10 bm_clk_en", bm_en, 1'b1);
        chk("R10 dis_ack", ack, 1'b0);
        chk("R10 not_ready", nrdy, 1'b0);
        chk("R10 rx_ignore", rx_ign, 1'b0);
        chk("R10 tx_recessive", tx_rec, 1'b0);

        // Intermission-based shutdown with drain
        quiet(); dis_req = 1; tick();
        chk("R1 waits", pe_en, 1'b1);
        bit_strobe = 1; imbit_idx = 3'd3; bus_level = 0; tick();
        chk("R11 dominant not safe", ack, 1'b0);
        imbit_idx = 3'd2; bus_level = 1; tick();
        chk("R11 wrong index not safe", ack, 1'b0);
        imbit_idx = 3'd3; bus_level = 1; move_busy = 1; tick();
        bit_strobe = 0; tick();
        chk("R2 busy holds clocks", pe_en, 1'b1);
        tick();
        chk("R2 busy holds ack", ack, 1'b0);
        move_busy = 0; tick();
        chk("R2 entered off", ack, 1'b1);
        chk("R1 clocks gated", pe_en, 1'b0);
        for (int s = 0; s < 4; s++) begin
            acc_sel = 2'(s); #1;
            chk("R6 region block", blk, s != 0);
        end
        acc_sel = 0;
        dis_req = 0; tick();
        chk("R7 clocks back", pe_en, 1'b1);
        chk("R7 ack clear", ack, 1'b0);
        chk("R8 nr held", nrdy, 1'b1);
        tick();
        chk("R8 nr cleared", nrdy, 1'b0);

        // Abort from bus wait
        dis_req = 1; tick();
        dis_req = 0; tick();
        chk("R9 abort bus wait clk", pe_en, 1'b1);
        chk("R9 abort bus wait nr", nrdy, 1'b0);
        // Abort from drain
        dis_req = 1; move_busy = 1; bus_off = 1; tick(); tick();
        bus_off = 0; dis_req = 0; tick();
        chk("R9 abort drain clk", bm_en, 1'b1);
        chk("R9 abort drain ack", ack, 1'b0);
        tick();
        chk("R9 stays running", nrdy, 1'b0);
        quiet();

        // Shaped random phase
        void'($urandom(seed_v));
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 100) < 12) dis_req = ~dis_req;
            bus_idle   = (($urandom % 100) < 5);
            bus_off    = (($urandom % 100) < 3);
            bit_strobe = (($urandom % 100) < 40);
            imbit_idx  = 3'($urandom % 5);
            bus_level  = (($urandom % 100) < 60);
            move_busy  = (($urandom % 100) < 50);
            acc_sel    = 2'($urandom % 4);
            tick();
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule